// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the initiator side of a two-wire station management bus. It turns one command into a complete clause-22 style read or write frame toward a PHY register file. It makes the management clock from the system clock with a divide ratio set at the command port. It drives the serial data line, or releases it. It leaves the open-drain pad to the surrounding logic as three signals: an output value, an output enable and an input.

A command carries the operation (read or write), a 5-bit PHY address, a 5-bit register address, 16 bits of write data and the half-period of the management clock in system cycles. The command is taken in the cycle where `cmd_valid` is high and `busy` is low. After that, `busy` stays high through the whole frame and a short trailing idle stretch. `done` then pulses for one cycle. For a read, the 16 bits returned by the PHY are on `rd_data` at that point and stay there until the next read collects new data.

Top module: `mdio_master`

## Requirements
- R1: A command is accepted only in a cycle with `cmd_valid` high and `busy` low, and `busy` is high from the next cycle on. A `cmd_valid` pulse while `busy` is high starts no frame and does not change the frame in progress.
- R2: Each frame is 64 bits long and contains, in order: 32 one bits, the start pattern 0 then 1, the opcode (1,0 for read; 0,1 for write), the PHY address and then the register address, each 5 bits with the MSB first.
- R3: With an effective half-period h, each bit lasts 2h system cycles: MDC is low for the first h cycles and high for the last h. The first bit begins at the acceptance edge with MDC low, and MDC rises for bit n exactly (2n+1)h cycles after the acceptance edge.
- R4: `mdio_o` and `mdio_oe` change only together with a falling MDC edge or at acceptance, and never while MDC stays high.
- R5: In a write frame, `mdio_oe` is high for all 64 bits. Bits 46 and 47 (turnaround) are 1 then 0, and bits 48 to 63 carry the write data with bit 15 first.
- R6: In a read frame, `mdio_oe` is high for bits 0 to 45 and low from bit 46 through bit 63. The line is sampled on the MDC rising edge of bits 48 to 63, and the first sample becomes `rd_data[15]`.
- R7: After bit 63, MDC runs for GAP_BITS more periods (default 1) with `mdio_oe` low and `busy` still high, so frames are always separated by idle clocks.
- R8: `done` is high for exactly one cycle. It rises at the edge where `busy` falls, 2(64+GAP_BITS)h cycles after the acceptance edge.
- R9: `rd_data` is 0 after reset. It does not change while `busy` is low, and a write frame leaves it unchanged.
- R10: While `busy` is low, MDC and `mdio_oe` are low. After reset, `busy` and `done` are low.
- R11: A half-period input of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command request |
| cmd_read | input | 1 | 1 = read frame, 0 = write frame |
| cmd_phy | input | 5 | Target PHY address |
| cmd_reg | input | 5 | Target register address |
| cmd_wdata | input | 16 | Data for a write frame |
| half_period | input | DIV_W | MDC half-period in system cycles, taken at acceptance |
| busy | output | 1 | Frame or trailing idle in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data collected by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line level seen at the pad |

## Verification
Every result is tied to the acceptance edge and to h. The MDC rise for bit n falls (2n+1)h system cycles later, the bits after the frame rise at the same pitch, and `done` follows 2(64+GAP_BITS)h cycles after acceptance. The monitor counts system cycles on the falling clock edge and compares that count at each MDC rise and at the `done` edge, so each sample is taken in the cycle the requirement names and not merely somewhere inside a window. It reads the frame bits and the enable at MDC rises, where they have been stable for h cycles. It checks `rd_data` in the `done` cycle, and the behavioural PHY checks the released turnaround bit from its own MDC edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FRAME = 2'd1,
    SEQ_GAP   = 2'd2
  } seq_state_e;

  localparam logic [1:0] SOF_PAT  = 2'b01;
  localparam logic [1:0] OPC_RD   = 2'b10;
  localparam logic [1:0] OPC_WR   = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;
  localparam logic [1:0] TA_RD    = 2'b11;

  localparam int ADDR_BITS = 5;
  localparam int DATA_BITS = 16;
  // start + opcode + two addresses + turnaround + data
  localparam int BODY_BITS = 2 + 2 + 2 * ADDR_BITS + 2 + DATA_BITS;
  // offset of the turnaround field behind the preamble
  localparam int TA_OFS    = 2 + 2 + 2 * ADDR_BITS;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] half_in,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);

  logic [DIV_W-1:0] half_q, half_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             ph_q, ph_n;
  logic             wrap;

  assign wrap     = (cnt_q == half_q - 1'b1);
  assign rise_stb = run && wrap && !ph_q;
  assign fall_stb = run && wrap && ph_q;
  assign mdc      = ph_q;

  always_comb begin
    half_n = half_q;
    cnt_n  = cnt_q;
    ph_n   = ph_q;
    if (start) begin
      half_n = (half_in == '0) ? DIV_W'(1) : half_in;
      cnt_n  = '0;
      ph_n   = 1'b0;
    end else if (run) begin
      if (wrap) begin
        cnt_n = '0;
        ph_n  = ~ph_q;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else begin
      cnt_n = '0;
      ph_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= DIV_W'(1);
      cnt_q  <= '0;
      ph_q   <= 1'b0;
    end else begin
      half_q <= half_n;
      cnt_q  <= cnt_n;
      ph_q   <= ph_n;
    end
  end

  // R3: a new frame always opens with the clock low and the phase count cleared
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!mdc && cnt_q == '0));

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter int GAP_BITS   = 1,
  parameter int TA_IDX     = 46,
  parameter int DATA_IDX   = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_read,
  input  logic rise_stb,
  input  logic fall_stb,
  output logic busy,
  output logic done,
  output logic drive_en,
  output logic shift_en,
  output logic sample_en
);

  localparam int CNT_MAX = (FRAME_BITS > GAP_BITS) ? FRAME_BITS : GAP_BITS;
  localparam int CNT_W   = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_G = CNT_W'(GAP_BITS - 1);
  localparam logic [CNT_W-1:0] TA_B   = CNT_W'(TA_IDX);
  localparam logic [CNT_W-1:0] DAT_B  = CNT_W'(DATA_IDX);

  seq_state_e       st_q, st_n;
  logic [CNT_W-1:0] bidx_q, bidx_n;
  logic             rd_q, rd_n;
  logic             done_q, done_n;

  always_comb begin
    st_n   = st_q;
    bidx_n = bidx_q;
    rd_n   = rd_q;
    done_n = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          st_n   = SEQ_FRAME;
          bidx_n = '0;
          rd_n   = start_read;
        end
      end
      SEQ_FRAME: begin
        if (fall_stb) begin
          if (bidx_q == LAST_F) begin
            st_n   = SEQ_GAP;
            bidx_n = '0;
          end else begin
            bidx_n = bidx_q + 1'b1;
          end
        end
      end
      SEQ_GAP: begin
        if (fall_stb) begin
          if (bidx_q == LAST_G) begin
            st_n   = SEQ_IDLE;
            bidx_n = '0;
            done_n = 1'b1;
          end else begin
            bidx_n = bidx_q + 1'b1;
          end
        end
      end
      default: st_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      bidx_q <= '0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      bidx_q <= bidx_n;
      rd_q   <= rd_n;
      done_q <= done_n;
    end
  end

  assign busy      = (st_q != SEQ_IDLE);
  assign done      = done_q;
  assign drive_en  = (st_q == SEQ_FRAME) && !(rd_q && bidx_q >= TA_B);
  assign shift_en  = (st_q == SEQ_FRAME) && fall_stb;
  assign sample_en = (st_q == SEQ_FRAME) && rd_q && (bidx_q >= DAT_B) && rise_stb;

  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: the pulse coincides with the end of busy
  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_LEN    = 32,
  parameter int FRAME_BITS = PRE_LEN + BODY_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 ld_read,
  input  logic [ADDR_BITS-1:0] ld_phy,
  input  logic [ADDR_BITS-1:0] ld_reg,
  input  logic [DATA_BITS-1:0] ld_wdata,
  input  logic                 shift_en,
  input  logic                 sample_en,
  input  logic                 rx_bit,
  output logic                 tx_bit,
  output logic [DATA_BITS-1:0] rx_data
);

  logic [FRAME_BITS-1:0] tx_q, tx_n;
  logic [DATA_BITS-1:0]  rx_q, rx_n;

  always_comb begin
    tx_n = tx_q;
    if (load) begin
      tx_n = {{PRE_LEN{1'b1}}, SOF_PAT,
              ld_read ? OPC_RD : OPC_WR,
              ld_phy, ld_reg,
              ld_read ? TA_RD : TA_WR,
              ld_read ? {DATA_BITS{1'b1}} : ld_wdata};
    end else if (shift_en) begin
      tx_n = {tx_q[FRAME_BITS-2:0], 1'b1};
    end
  end

  always_comb begin
    rx_n = rx_q;
    if (sample_en) begin
      rx_n = {rx_q[DATA_BITS-2:0], rx_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '1;
      rx_q <= '0;
    end else begin
      tx_q <= tx_n;
      rx_q <= rx_n;
    end
  end

  assign tx_bit  = tx_q[FRAME_BITS-1];
  assign rx_data = rx_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int PRE_LEN  = 32,
  parameter int GAP_BITS = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_read,
  input  logic [ADDR_BITS-1:0] cmd_phy,
  input  logic [ADDR_BITS-1:0] cmd_reg,
  input  logic [DATA_BITS-1:0] cmd_wdata,
  input  logic [DIV_W-1:0]     half_period,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  input  logic                 mdio_i
);

  localparam int FRAME_BITS = PRE_LEN + BODY_BITS;
  localparam int TA_IDX     = PRE_LEN + TA_OFS;
  localparam int DATA_IDX   = TA_IDX + 2;

  logic start;
  logic rise_stb, fall_stb;
  logic shift_en, sample_en;

  assign start = cmd_valid && !busy;

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .run      (busy),
    .half_in  (half_period),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_seq #(
    .FRAME_BITS (FRAME_BITS),
    .GAP_BITS   (GAP_BITS),
    .TA_IDX     (TA_IDX),
    .DATA_IDX   (DATA_IDX)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_read (cmd_read),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .busy       (busy),
    .done       (done),
    .drive_en   (mdio_oe),
    .shift_en   (shift_en),
    .sample_en  (sample_en)
  );

  mdio_shifter #(
    .PRE_LEN    (PRE_LEN),
    .FRAME_BITS (FRAME_BITS)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .ld_read   (cmd_read),
    .ld_phy    (cmd_phy),
    .ld_reg    (cmd_reg),
    .ld_wdata  (cmd_wdata),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .rx_bit    (mdio_i),
    .tx_bit    (mdio_o),
    .rx_data   (rd_data)
  );

  // R1: an accepted command raises busy in the following cycle
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  // R4: the line value and enable hold while the clock stays high
  p_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R9: read data is frozen while idle
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rd_data));

  // R10: the bus is quiet while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FB         = 64;
  localparam int GAPB       = 1;
  localparam logic [4:0] PHY_ADDR = 5'd3;

  typedef struct packed {
    logic [63:0] bits;
    logic        rd;
    logic [7:0]  h;
  } fexp_t;

  typedef struct packed {
    logic        rd;
    logic [15:0] val;
  } rexp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_read;
  logic [4:0]  cmd_phy, cmd_reg;
  logic [15:0] cmd_wdata;
  logic [7:0]  half_period;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        phy_oe = 1'b0;
  logic        phy_o  = 1'b1;
  logic        line;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int r4_bad   = 0;
  int r10_bad  = 0;
  int clash    = 0;

  fexp_t fq[$];
  rexp_t rq[$];
  logic [15:0] shadow  [32];
  logic [15:0] phy_mem [32];
  logic [15:0] last_rd = 16'h0000;

  assign line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .half_period(half_period), .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // system cycle counter, stepped away from the active edge
  logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) r4_bad++;
      if (!busy && (mdc || mdio_oe)) r10_bad++;
      if (phy_oe && mdio_oe) clash++;
    end
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
  end

  // behavioural PHY with a 32-entry register file
  initial begin
    int ones;
    logic [11:0] hdr;
    logic [17:0] wbits;
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'h1000 + 16'(i);
    forever begin
      ones = 0;
      while (1) begin
        @(posedge mdc);
        if (line) ones++;
        else if (ones >= 32) break;
        else ones = 0;
      end
      @(posedge mdc);
      if (line !== 1'b1) continue;
      for (int i = 0; i < 12; i++) begin
        @(posedge mdc);
        hdr = {hdr[10:0], line};
      end
      if (hdr[11:10] == 2'b10 && hdr[9:5] == PHY_ADDR) begin
        @(negedge mdc);
        @(posedge mdc);
        chk(mdio_oe == 1'b0, "R6 first turnaround released", 64'(mdio_oe), 64'h0);
        @(negedge mdc);
        phy_oe = 1'b1; phy_o = 1'b0;
        for (int i = 15; i >= 0; i--) begin
          @(negedge mdc);
          phy_o = phy_mem[hdr[4:0]][i];
        end
        @(negedge mdc);
        phy_oe = 1'b0; phy_o = 1'b1;
      end else if (hdr[11:10] == 2'b01) begin
        for (int i = 0; i < 18; i++) begin
          @(posedge mdc);
          wbits = {wbits[16:0], line};
        end
        chk(wbits[17:16] == 2'b10, "R5 write turnaround", 64'(wbits[17:16]), 64'h2);
        if (hdr[9:5] == PHY_ADDR) phy_mem[hdr[4:0]] = wbits[15:0];
      end
    end
  end

  // frame monitor: bit values, enable and MDC timing per bit
  initial begin
    fexp_t fe;
    int c0, h, bad_n, tbad_n, gbad;
    logic [63:0] b_act, b_exp;
    bit exp_oe;
    forever begin
      @(posedge busy);
      c0 = cyc;
      chk(mdc == 1'b0, "R3 first bit starts low", 64'(mdc), 64'h0);
      if (fq.size() == 0) begin
        chk(1'b0, "R1 frame without accepted command", 64'h1, 64'h0);
        continue;
      end
      fe = fq.pop_front();
      h = (fe.h == 0) ? 1 : int'(fe.h);
      bad_n = -1; tbad_n = -1; gbad = 0; b_act = '0; b_exp = '0;
      for (int n = 0; n < FB + GAPB; n++) begin
        @(posedge mdc);
        if (cyc != c0 + (2*n + 1)*h && tbad_n < 0) tbad_n = n;
        if (n < FB) begin
          exp_oe = !(fe.rd && n >= 46);
          if (bad_n < 0 && (mdio_oe !== exp_oe ||
              (exp_oe && mdio_o !== fe.bits[63-n]))) begin
            bad_n = n;
            b_act = {62'h0, mdio_oe, mdio_o};
            b_exp = {62'h0, exp_oe, fe.bits[63-n]};
          end
        end else if (mdio_oe !== 1'b0 || busy !== 1'b1) begin
          gbad++;
        end
      end
      chk(bad_n < 0, fe.rd ? "R2/R6 read frame bits and enable"
                           : "R2/R5 write frame bits and enable", b_act, b_exp);
      chk(tbad_n < 0, "R3 MDC rise timing per bit", 64'(tbad_n), 64'hFFFF_FFFF_FFFF_FFFF);
      chk(gbad == 0, "R7 trailing idle released", 64'(gbad), 64'h0);
      @(posedge done);
      chk(cyc == c0 + 2*(FB + GAPB)*h, "R8 done timing", 64'(cyc - c0),
          64'(2*(FB + GAPB)*h));
    end
  end

  // scoreboard: read data at completion
  initial begin
    rexp_t re;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (rq.size() == 0) begin
          chk(1'b0, "R8 done without command", 64'h1, 64'h0);
        end else begin
          re = rq.pop_front();
          chk(rd_data == re.val, re.rd ? "R6 read data" : "R9 write keeps rd_data",
              64'(rd_data), 64'(re.val));
        end
        @(negedge clk);
        chk(done == 1'b0, "R8 single-cycle done", 64'(done), 64'h0);
      end
    end
  end

  task automatic issue(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input logic [7:0] hp);
    fexp_t fe;
    rexp_t re;
    @(negedge clk);
    while (busy) @(negedge clk);
    fe.bits = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra,
               rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : wd};
    fe.rd = rd;
    fe.h  = hp;
    fq.push_back(fe);
    re.rd = rd;
    if (rd) begin
      re.val  = (pa == PHY_ADDR) ? shadow[ra] : 16'hFFFF;
      last_rd = re.val;
    end else begin
      re.val = last_rd;
      if (pa == PHY_ADDR) shadow[ra] = wd;
    end
    rq.push_back(re);
    cmd_read = rd; cmd_phy = pa; cmd_reg = ra; cmd_wdata = wd; half_period = hp;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || rq.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = 16'h1000 + 16'(i);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_read = 1'b0; cmd_phy = '0;
    cmd_reg = '0; cmd_wdata = '0; half_period = 8'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R10 reset busy/done", {busy, done}, 0);
    chk(mdc == 0 && mdio_oe == 0, "R10 reset bus quiet", {mdc, mdio_oe}, 0);
    chk(rd_data == 16'h0, "R9 reset rd_data", 64'(rd_data), 0);

    // write then read back
    issue(0, PHY_ADDR, 5'd5, 16'hA5C3, 8'd4);
    issue(1, PHY_ADDR, 5'd5, 16'h0000, 8'd4);
    // register-address extremes, back to back
    issue(0, PHY_ADDR, 5'd0, 16'h8001, 8'd3);
    issue(0, PHY_ADDR, 5'd31, 16'h7FFE, 8'd3);
    issue(1, PHY_ADDR, 5'd31, 16'h0000, 8'd3);
    issue(1, PHY_ADDR, 5'd0, 16'h0000, 8'd3);
    // untouched register, then an absent PHY (line stays pulled high)
    issue(1, PHY_ADDR, 5'd12, 16'h0000, 8'd2);
    issue(1, 5'd9, 5'd12, 16'h0000, 8'd2);
    // write after read keeps rd_data (R9)
    issue(0, PHY_ADDR, 5'd12, 16'h0000, 8'd2);
    issue(1, PHY_ADDR, 5'd12, 16'h0000, 8'd2);
    // half-period 0 behaves as 1 (R11)
    issue(0, PHY_ADDR, 5'd7, 16'h0F0F, 8'd0);
    issue(1, PHY_ADDR, 5'd7, 16'h0000, 8'd0);
    issue(1, PHY_ADDR, 5'd7, 16'h0000, 8'd1);
    wait_idle();

    // R1: request during busy is ignored
    issue(0, PHY_ADDR, 5'd9, 16'h3C3C, 8'd2);
    repeat (20) @(negedge clk);
    cmd_read = 1'b1; cmd_phy = PHY_ADDR; cmd_reg = 5'd1; half_period = 8'd1;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(busy == 0 && fq.size() == 0, "R1 request while busy ignored",
        {busy, 32'(fq.size())}, 0);
    issue(1, PHY_ADDR, 5'd9, 16'h0000, 8'd2);
    wait_idle();
    repeat (10) @(negedge clk);

    chk(r4_bad == 0, "R4 line stable while MDC high", 64'(r4_bad), 0);
    chk(r10_bad == 0, "R10 idle bus quiet", 64'(r10_bad), 0);
    chk(clash == 0, "R6 no drive overlap on read", 64'(clash), 0);
    finish_run();
  end

endmodule